// File: doc/BRIEF.md
# Banked Write-One-To-Clear Fault Status Register

This block is the fault status storage inside a small processor's system interrupt controller. It holds a 32-bit configurable fault status word in two copies, one per security state, and a 32-bit hard fault status word. Fault-detection logic elsewhere raises status bits through event inputs. Software reads the words and clears bits by writing ones over a simple request/response bus. The bus accepts byte, halfword and word accesses, and each access carries a security attribute.

The byte that holds bits [15:8] of the configurable word exists only once. It lives in the non-secure copy, and both security states see it. A sub-word access is realigned by its byte lane inside the 32-bit word. Every bus request gets exactly one response, one cycle later, and the response carries an error flag for accesses that fall outside the decoded words.

The response side is a three-state machine:
- `ST_IDLE`: no response is presented.
- `ST_ACK`: a good response is presented, carrying read data.
- `ST_NAK`: an error response is presented.

Its transitions are:
- IDLE/ACK/NAK -> ACK, on a valid request that decodes.
- IDLE/ACK/NAK -> NAK, on a valid request that does not decode.
- IDLE/ACK/NAK -> IDLE, when no request is present.

Top module: `fsr_regfile`

## Requirements
- R1: After reset both copies of the configurable word and the hard fault word read as zero, and `rsp_valid` is low.
- R2: Every cycle with `req_valid` high is followed, in the next cycle, by exactly one cycle of `rsp_valid`. Without a request, `rsp_valid` stays low.
- R3: An access is answered with `rsp_err` high, zero read data and no change of state if any of the following holds:
  - `req_size` is 3.
  - Offset plus byte count runs past 0xD2B for an access starting in 0xD28..0xD2B.
  - A non-word access is made at 0xD2C.
  - The offset is any other value.
- R4: A read at offset 0xD28+k returns (selected copy OR non-secure bits [15:8]) shifted right by 8*k, truncated to the access size. The size codes are 0 = 1 byte, 1 = 2 bytes and 2 = 4 bytes, and bits above the access size read as zero.
- R5: A write to 0xD28+k clears, in the copy selected by `req_secure`, each bit set in (write data truncated to the access size) shifted left by 8*k. Byte lanes outside the access keep their value.
- R6: A secure write also applies its shifted clear pattern to bits [15:8] of the non-secure copy. A non-secure write never alters the secure copy.
- R7: An event with `evt_secure` = 1 sets its mask bits outside [15:8] in the secure copy; an event with `evt_secure` = 0 sets them in the non-secure copy. Bits [15:8] of the mask are always set in the non-secure copy. The secure copy's bits [15:8] stay zero.
- R8: When an event set and a software clear hit the same bit in the same cycle, the bit ends set.
- R9: The hard fault word sits at offset 0xD2C and is reached by word accesses only. `hf_set` bits set it, a write clears the bits written as one, and a read returns it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Bus request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_secure | input | 1 | Security attribute of the access (1 = secure) |
| req_addr | input | 12 | Byte offset of the access |
| req_size | input | 2 | Size code: 0 byte, 1 halfword, 2 word |
| req_wdata | input | 32 | Write data, right-aligned |
| evt_valid | input | 1 | Fault event present |
| evt_secure | input | 1 | Copy targeted by the event |
| evt_mask | input | 32 | Status bits raised by the event |
| hf_set | input | 32 | Hard fault status bits to set |
| rsp_valid | output | 1 | Response present |
| rsp_err | output | 1 | Response reports a decode error |
| rsp_rdata | output | 32 | Read data, right-aligned |

## Verification
The bench builds the block with its default parameters: a 32-bit data path, a 12-bit offset, the configurable word based at 0xD28 and the shared byte at bits [15:8]. This setting puts every lane alignment within reach: byte, halfword and word reads and writes starting at each of the four lanes. The 0xD2C boundary, where a legal start address with an oversized access must be refused, is also reachable. The setting reaches the shared byte from both security states, so secure clears that reach into the non-secure copy can be observed, along with set-versus-clear collisions on the same cycle.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ACK  = 2'd1,
        ST_NAK  = 2'd2
    } rsp_state_e;

    localparam int unsigned NUM_BANKS = 2;
    localparam int unsigned BANK_NS   = 0;
    localparam int unsigned BANK_SEC  = 1;
endpackage

// File: rtl/fsr_decode.sv
module fsr_decode #(
    parameter int unsigned        DATA_W    = 32,
    parameter int unsigned        ADDR_W    = 12,
    parameter logic [ADDR_W-1:0]  STAT_BASE = 12'hD28,
    parameter logic [ADDR_W-1:0]  HARD_OFF  = 12'hD2C
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size,
    input  logic [DATA_W-1:0] wdata,
    output logic              hit_stat,
    output logic              hit_hard,
    output logic              acc_bad,
    output logic [4:0]        lane_shift,
    output logic [DATA_W-1:0] size_mask,
    output logic [DATA_W-1:0] clr_vec
);
    logic [ADDR_W-1:0] off;
    logic [1:0]        lane;
    logic [2:0]        nbytes;
    logic [3:0]        last_end;

    always_comb begin
        off       = addr - STAT_BASE;
        lane      = off[1:0];
        unique case (size)
            2'd0:    nbytes = 3'd1;
            2'd1:    nbytes = 3'd2;
            default: nbytes = 3'd4;
        endcase
        last_end  = {2'b00, lane} + {1'b0, nbytes};
        unique case (size)
            2'd0:    size_mask = DATA_W'(8'hFF);
            2'd1:    size_mask = DATA_W'(16'hFFFF);
            default: size_mask = '1;
        endcase
        hit_stat   = (size != 2'd3) && (addr >= STAT_BASE) &&
                     (off < ADDR_W'(4)) && (last_end <= 4'd4);
        hit_hard   = (addr == HARD_OFF) && (size == 2'd2);
        acc_bad    = !(hit_stat || hit_hard);
        lane_shift = {lane, 3'b000};
        clr_vec    = (wdata & size_mask) << lane_shift;
    end
endmodule

// File: rtl/fsr_bank_store.sv
module fsr_bank_store
    import fsr_pkg::*;
#(
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned SHARED_LO = 8,
    parameter int unsigned SHARED_HI = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stat_clr_en,
    input  logic              stat_clr_sec,
    input  logic [DATA_W-1:0] stat_clr_vec,
    input  logic              hard_clr_en,
    input  logic [DATA_W-1:0] hard_clr_vec,
    input  logic              evt_valid,
    input  logic              evt_secure,
    input  logic [DATA_W-1:0] evt_mask,
    input  logic [DATA_W-1:0] hf_set,
    output logic [DATA_W-1:0] ns_q,
    output logic [DATA_W-1:0] sec_q,
    output logic [DATA_W-1:0] hf_q
);
    localparam int unsigned SH_W = SHARED_HI - SHARED_LO + 1;
    localparam logic [DATA_W-1:0] SHARED_MASK = DATA_W'({SH_W{1'b1}}) << SHARED_LO;

    logic [DATA_W-1:0] clr_b [NUM_BANKS];
    logic [DATA_W-1:0] set_b [NUM_BANKS];
    logic [DATA_W-1:0] bank_q[NUM_BANKS];

    always_comb begin
        clr_b[BANK_NS]  = '0;
        clr_b[BANK_SEC] = '0;
        set_b[BANK_NS]  = '0;
        set_b[BANK_SEC] = '0;
        if (stat_clr_en) begin
            if (stat_clr_sec) begin
                clr_b[BANK_SEC] = stat_clr_vec & ~SHARED_MASK;
                clr_b[BANK_NS]  = stat_clr_vec & SHARED_MASK;
            end else begin
                clr_b[BANK_NS]  = stat_clr_vec;
            end
        end
        if (evt_valid) begin
            if (evt_secure) begin
                set_b[BANK_SEC] = evt_mask & ~SHARED_MASK;
                set_b[BANK_NS]  = evt_mask & SHARED_MASK;
            end else begin
                set_b[BANK_NS]  = evt_mask;
            end
        end
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) bank_q[b] <= '0;
            else        bank_q[b] <= (bank_q[b] & ~clr_b[b]) | set_b[b];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hf_q <= '0;
        else        hf_q <= (hf_q & ~(hard_clr_en ? hard_clr_vec : '0)) | hf_set;
    end

    assign ns_q  = bank_q[BANK_NS];
    assign sec_q = bank_q[BANK_SEC];
endmodule

// File: rtl/fsr_rsp_fsm.sv
module fsr_rsp_fsm
    import fsr_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              acc_bad,
    input  logic [DATA_W-1:0] rd_word,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [DATA_W-1:0] rsp_rdata
);
    rsp_state_e        state_q, state_d;
    logic [DATA_W-1:0] rdata_q;

    always_comb begin
        state_d = ST_IDLE;
        if (req_valid) state_d = acc_bad ? ST_NAK : ST_ACK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            rdata_q <= '0;
        end else begin
            state_q <= state_d;
            rdata_q <= (state_d == ST_ACK) ? rd_word : '0;
        end
    end

    always_comb begin
        rsp_valid = 1'b0;
        rsp_err   = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_ACK:  rsp_valid = 1'b1;
            ST_NAK:  begin rsp_valid = 1'b1; rsp_err = 1'b1; end
            default: ;
        endcase
        rsp_rdata = rdata_q;
    end
endmodule

// File: rtl/fsr_regfile.sv
module fsr_regfile #(
    parameter int unsigned        DATA_W    = 32,
    parameter int unsigned        ADDR_W    = 12,
    parameter logic [ADDR_W-1:0]  STAT_BASE = 12'hD28,
    parameter logic [ADDR_W-1:0]  HARD_OFF  = 12'hD2C,
    parameter int unsigned        SHARED_LO = 8,
    parameter int unsigned        SHARED_HI = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_secure,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              evt_valid,
    input  logic              evt_secure,
    input  logic [DATA_W-1:0] evt_mask,
    input  logic [DATA_W-1:0] hf_set,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [DATA_W-1:0] rsp_rdata
);
    localparam int unsigned SH_W = SHARED_HI - SHARED_LO + 1;
    localparam logic [DATA_W-1:0] SHARED_MASK = DATA_W'({SH_W{1'b1}}) << SHARED_LO;

    logic              hit_stat, hit_hard, acc_bad;
    logic [4:0]        lane_shift;
    logic [DATA_W-1:0] size_mask, clr_vec;
    logic [DATA_W-1:0] ns_q, sec_q, hf_q;
    logic [DATA_W-1:0] view_word, rd_word;
    logic              wr_ok;

    fsr_decode #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W),
        .STAT_BASE(STAT_BASE), .HARD_OFF(HARD_OFF)
    ) u_decode (
        .addr(req_addr), .size(req_size), .wdata(req_wdata),
        .hit_stat(hit_stat), .hit_hard(hit_hard), .acc_bad(acc_bad),
        .lane_shift(lane_shift), .size_mask(size_mask), .clr_vec(clr_vec)
    );

    assign wr_ok = req_valid && req_write && !acc_bad;

    fsr_bank_store #(
        .DATA_W(DATA_W), .SHARED_LO(SHARED_LO), .SHARED_HI(SHARED_HI)
    ) u_store (
        .clk(clk), .rst_n(rst_n),
        .stat_clr_en(wr_ok && hit_stat), .stat_clr_sec(req_secure),
        .stat_clr_vec(clr_vec),
        .hard_clr_en(wr_ok && hit_hard), .hard_clr_vec(req_wdata),
        .evt_valid(evt_valid), .evt_secure(evt_secure), .evt_mask(evt_mask),
        .hf_set(hf_set),
        .ns_q(ns_q), .sec_q(sec_q), .hf_q(hf_q)
    );

    always_comb begin
        view_word = (req_secure ? sec_q : ns_q) | (ns_q & SHARED_MASK);
        if (req_write)     rd_word = '0;
        else if (hit_hard) rd_word = hf_q;
        else               rd_word = (view_word >> lane_shift) & size_mask;
    end

    fsr_rsp_fsm #(.DATA_W(DATA_W)) u_rsp (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .acc_bad(acc_bad),
        .rd_word(rd_word),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata)
    );
endmodule

// File: rtl/fsr_checker.sv
module fsr_checker #(
    parameter int unsigned DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_write,
    input logic              req_secure,
    input logic [1:0]        req_size,
    input logic              acc_bad,
    input logic              hit_stat,
    input logic              evt_valid,
    input logic              evt_secure,
    input logic [DATA_W-1:0] evt_mask,
    input logic [DATA_W-1:0] hf_set,
    input logic [DATA_W-1:0] clr_vec,
    input logic [DATA_W-1:0] ns_q,
    input logic [DATA_W-1:0] sec_q,
    input logic [DATA_W-1:0] hf_q,
    input logic              rsp_valid,
    input logic              rsp_err,
    input logic [DATA_W-1:0] rsp_rdata
);
    AST_RSP_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid); // R2
    AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid); // R2
    AST_BAD_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && acc_bad) |=> (rsp_err && rsp_rdata == '0)); // R3
    AST_BAD_KEEPS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && acc_bad && !evt_valid && hf_set == '0)
        |=> ($stable(ns_q) && $stable(sec_q) && $stable(hf_q))); // R3
    AST_BYTE_READ_TRUNC: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && req_size == 2'd0) |=> (rsp_rdata[DATA_W-1:8] == '0)); // R4
    AST_SECURE_CLEARS_SHARED: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && req_secure && hit_stat && !evt_valid)
        |=> ((ns_q & $past(clr_vec) & DATA_W'(32'h0000FF00)) == '0)); // R6
    AST_SEC_SHARED_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        sec_q[15:8] == 8'h00); // R7
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && !evt_secure) |=> ((ns_q & $past(evt_mask)) == $past(evt_mask))); // R8
endmodule

bind fsr_regfile fsr_checker #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_secure(req_secure), .req_size(req_size), .acc_bad(acc_bad),
    .hit_stat(hit_stat), .evt_valid(evt_valid), .evt_secure(evt_secure),
    .evt_mask(evt_mask), .hf_set(hf_set), .clr_vec(clr_vec),
    .ns_q(ns_q), .sec_q(sec_q), .hf_q(hf_q),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata)
);

// File: tb/fsr_regfile_bench.sv
module fsr_regfile_bench;
    localparam logic [31:0] SH = 32'h0000FF00;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, req_secure = 1'b0;
    logic [11:0] req_addr = '0;
    logic [1:0]  req_size = '0;
    logic [31:0] req_wdata = '0;
    logic        evt_valid = 1'b0, evt_secure = 1'b0;
    logic [31:0] evt_mask = '0, hf_set = '0;
    logic        rsp_valid, rsp_err;
    logic [31:0] rsp_rdata;

    int n_vec = 0;
    int n_bad = 0;

    typedef struct {
        logic        err;
        logic [31:0] rd;
        string       tag;
    } exp_t;
    exp_t sb[$];

    logic [31:0] m_ns = '0, m_sec = '0, m_hf = '0;

    always #2 clk = ~clk;

    fsr_regfile u_fsr_regfile (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_secure(req_secure), .req_addr(req_addr), .req_size(req_size),
        .req_wdata(req_wdata), .evt_valid(evt_valid), .evt_secure(evt_secure),
        .evt_mask(evt_mask), .hf_set(hf_set),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata)
    );

    // One bus cycle, optionally with a fault event and hard fault set.
    task automatic cyc(input logic v, input logic wr, input logic sec,
                       input logic [11:0] a, input logic [1:0] sz, input logic [31:0] wd,
                       input logic ev, input logic es, input logic [31:0] em,
                       input logic [31:0] hs, input string tag);
        logic        stat_ok, hard_ok;
        logic [31:0] smask, view, clr;
        int          lane;
        exp_t        e;
        @(negedge clk);
        req_valid = v; req_write = wr; req_secure = sec; req_addr = a;
        req_size = sz; req_wdata = wd; evt_valid = ev; evt_secure = es;
        evt_mask = em; hf_set = hs;
        smask = (sz == 2'd0) ? 32'hFF : (sz == 2'd1) ? 32'hFFFF : 32'hFFFF_FFFF;
        lane = int'(a) - 'hD28;
        stat_ok = (sz != 2'd3) && lane >= 0 && lane < 4 && (lane + (1 << sz)) <= 4;
        hard_ok = (a == 12'hD2C) && (sz == 2'd2);
        if (v) begin
            e.tag = tag;
            e.err = !(stat_ok || hard_ok);
            e.rd  = '0;
            if (!wr && stat_ok) begin
                view = (sec ? m_sec : m_ns) | (m_ns & SH);
                e.rd = (view >> (lane * 8)) & smask;
            end else if (!wr && hard_ok) begin
                e.rd = m_hf;
            end
            sb.push_back(e);
            if (wr && stat_ok) begin
                clr = (wd & smask) << (lane * 8);
                if (sec) begin
                    m_sec = m_sec & ~(clr & ~SH);
                    m_ns  = m_ns & ~(clr & SH);
                end else begin
                    m_ns = m_ns & ~clr;
                end
            end
            if (wr && hard_ok) m_hf = m_hf & ~wd;
        end
        if (ev) begin
            if (es) begin
                m_sec = m_sec | (em & ~SH);
                m_ns  = m_ns | (em & SH);
            end else begin
                m_ns = m_ns | em;
            end
        end
        m_hf = m_hf | hs;
    endtask

    task automatic rd(input logic sec, input logic [11:0] a, input logic [1:0] sz, input string tag);
        cyc(1'b1, 1'b0, sec, a, sz, '0, 1'b0, 1'b0, '0, '0, tag);
    endtask

    task automatic wr(input logic sec, input logic [11:0] a, input logic [1:0] sz,
                      input logic [31:0] d, input string tag);
        cyc(1'b1, 1'b1, sec, a, sz, d, 1'b0, 1'b0, '0, '0, tag);
    endtask

    task automatic evt(input logic sec, input logic [31:0] m);
        cyc(1'b0, 1'b0, 1'b0, '0, '0, '0, 1'b1, sec, m, '0, "");
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 1'b0, '0, '0, '0, 1'b0, 1'b0, '0, '0, "");
    endtask

    // Monitor: pops one expected item per response.
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            exp_t e;
            n_vec++;
            if (sb.size() == 0) begin
                n_bad++;
                $display("FAIL R2: response with nothing outstanding act=1 exp=0");
            end else begin
                e = sb.pop_front();
                if (rsp_err !== e.err || rsp_rdata !== e.rd) begin
                    n_bad++;
                    $display("FAIL %s: act err=%0b data=%08h exp err=%0b data=%08h",
                             e.tag, rsp_err, rsp_rdata, e.err, e.rd);
                end
            end
        end
    end

    initial begin : watchdog
        #400000;
        n_bad++;
        $display("FAIL watchdog: act=expired exp=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        n_vec++;
        if (rsp_valid !== 1'b0) begin
            n_bad++;
            $display("FAIL R1: rsp_valid in reset act=%0b exp=0", rsp_valid);
        end
        rst_n = 1'b1;
        // R1: everything reads zero after reset
        rd(1'b0, 12'hD28, 2'd2, "R1");
        rd(1'b1, 12'hD28, 2'd2, "R1");
        rd(1'b0, 12'hD2C, 2'd2, "R1");
        idle(2);
        // R7: non-secure event, visible shared byte from both states
        evt(1'b0, 32'h0000_AB01);
        rd(1'b0, 12'hD28, 2'd2, "R7");
        rd(1'b1, 12'hD28, 2'd2, "R7");
        // R7: secure event, shared byte routed to non-secure copy
        evt(1'b1, 32'h0102_CD04);
        rd(1'b1, 12'hD28, 2'd2, "R7");
        rd(1'b0, 12'hD28, 2'd2, "R7");
        // R4: sub-word reads on each lane
        rd(1'b1, 12'hD29, 2'd0, "R4");
        rd(1'b1, 12'hD2A, 2'd1, "R4");
        rd(1'b1, 12'hD2B, 2'd0, "R4");
        rd(1'b0, 12'hD28, 2'd1, "R4");
        rd(1'b1, 12'hD28, 2'd0, "R4");
        // R3: errors, no state change
        rd(1'b0, 12'hD2A, 2'd2, "R3");
        rd(1'b0, 12'hD2B, 2'd1, "R3");
        rd(1'b0, 12'hD28, 2'd3, "R3");
        rd(1'b0, 12'hD2C, 2'd0, "R3");
        rd(1'b0, 12'hD30, 2'd2, "R3");
        wr(1'b0, 12'hD29, 2'd2, 32'hFFFF_FFFF, "R3");
        wr(1'b1, 12'hD27, 2'd0, 32'hFF, "R3");
        rd(1'b0, 12'hD28, 2'd2, "R3");
        rd(1'b1, 12'hD28, 2'd2, "R3");
        // R5: lane-shifted W1C
        wr(1'b0, 12'hD28, 2'd0, 32'hFFFF_FFFF, "R5");
        rd(1'b0, 12'hD28, 2'd2, "R5");
        wr(1'b1, 12'hD2A, 2'd0, 32'h0000_00FF, "R5");
        rd(1'b1, 12'hD28, 2'd2, "R5");
        // R6: secure write reaches shared byte; non-secure write leaves secure copy
        wr(1'b1, 12'hD29, 2'd0, 32'h0000_0020, "R6");
        rd(1'b0, 12'hD28, 2'd2, "R6");
        wr(1'b0, 12'hD28, 2'd2, 32'h0100_0004, "R6");
        rd(1'b1, 12'hD28, 2'd2, "R6");
        wr(1'b0, 12'hD2A, 2'd1, 32'h0000_FFFF, "R6");
        rd(1'b1, 12'hD28, 2'd2, "R6");
        // R8: set beats clear in the same cycle
        cyc(1'b1, 1'b1, 1'b0, 12'hD28, 2'd0, 32'h10, 1'b1, 1'b0, 32'h10, '0, "R8");
        rd(1'b0, 12'hD28, 2'd0, "R8");
        cyc(1'b1, 1'b1, 1'b1, 12'hD28, 2'd2, 32'h0000_0800, 1'b1, 1'b1, 32'h0000_0800, '0, "R8");
        rd(1'b1, 12'hD28, 2'd2, "R8");
        // R9: hard fault word
        cyc(1'b0, 1'b0, 1'b0, '0, '0, '0, 1'b0, 1'b0, '0, 32'h4000_0002, "");
        rd(1'b0, 12'hD2C, 2'd2, "R9");
        wr(1'b1, 12'hD2C, 2'd2, 32'h0000_0002, "R9");
        rd(1'b1, 12'hD2C, 2'd2, "R9");
        idle(3);
        n_vec++;
        if (sb.size() != 0) begin
            n_bad++;
            $display("FAIL R2: missing responses act=%0d exp=0", sb.size());
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule